// File: doc/BRIEF.md
# SDRAM Burst Interruption Engine

This block is the device-side burst machinery of a four-bank synchronous DRAM command port. It accepts one command per clock. Each command is NOP, WRITE or READ and comes with a bank select, a column address and an auto-precharge bit. It runs four-beat write and read bursts against a small register array indexed by bank and column. Read data leaves on the data output three clocks after the READ command. The byte mask input (DQM) does two jobs. It blocks array updates during write beats. During reads it blanks output beats two clocks after it is sampled.

The key behaviour is interruption. A WRITE or READ that arrives while a write burst is still running ends that burst on the same clock. Beats captured before the interruption stay in the array. The remaining beats are dropped. The new command starts its own burst at beat 0 and may use any bank and any column. When a READ interrupts a write, the data input value in that READ's clock never reaches the array. Row activation, refresh, mode programming and precharge timing are not modelled.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset, every array location reads as zero, `dqOe` is low, `dqOut` is zero and `apOut` is low.
- R2: `cmd` encoding is 2'b00 NOP, 2'b01 WRITE, 2'b10 READ, 2'b11 treated as NOP. A WRITE in cycle t stores `dqIn` of cycles t, t+1, t+2 and t+3 as beats 0 to 3. Beat n goes to column {col[3:2], col[1:0]+n mod 4}, in the bank given with the command.
- R3: A WRITE that arrives while a write burst is running ends that burst. Beats already stored are kept, no later beat of the old burst is stored, and the new burst stores its beat 0 in the same cycle. This applies on consecutive clocks and to any bank or column.
- R4: A READ that arrives while a write burst is running ends that burst, whether it targets the same bank or another bank. The `dqIn` value in the READ's cycle is not stored, and later beats of the old write are dropped.
- R5: A READ in cycle t drives beat n in cycle t+3+n with `dqOe` high. Beat n comes from the column ordering of R2 and reflects all writes stored before cycle t+n.
- R6: When `dqm` is high in a write beat's cycle, that beat leaves the array location unchanged. The other beats of the burst are still stored.
- R7: When `dqm` is high in cycle c, `dqOe` is low in cycle c+2.
- R8: `apIn` (column-address bit 10) is latched into `apOut` on every READ or WRITE. `apOut` holds its value on any other command.
- R9: `dqOut` is zero whenever `dqOe` is low.
- R10: A READ or WRITE that arrives while a read burst is running stops the remaining beats of that burst from being issued. Beats issued before that cycle still appear on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: NOP, WRITE, READ |
| bankSel | input | 2 | Bank select sampled with the command |
| colAddr | input | 4 | Start column sampled with the command |
| apIn | input | 1 | Auto-precharge bit (column-address bit 10) |
| dqIn | input | 8 | Write data |
| dqm | input | 1 | Write-beat mask and read-output blank |
| dqOut | output | 8 | Read data, zero when not enabled |
| dqOe | output | 1 | Read data output enable |
| apOut | output | 1 | Latched auto-precharge flag |

## Verification
A write beat takes effect at the clock edge that ends its own cycle, so a READ one clock later already sees it. Read beat n of a READ issued in cycle t is due in cycle t+3+n. A mask sampled in cycle c acts on the output of cycle c+2. `apOut` follows a command one cycle later. The bench keeps a cycle-indexed table of due output beats and mask slots, filled when each command is driven. It compares the outputs midway through each cycle against the entry for that cycle. The array contents are checked by read-back bursts that go through the same timed comparison.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  localparam int BANK_W    = 2;
  localparam int COL_W     = 4;
  localparam int DQ_W      = 8;
  localparam int BURST_LEN = 4;
  localparam int CAS_LAT   = 3;
  localparam int MASK_LAT  = 2;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic              wrEn;
    logic [BANK_W-1:0] wrBank;
    logic [COL_W-1:0]  wrCol;
    logic              rdEn;
    logic [BANK_W-1:0] rdBank;
    logic [COL_W-1:0]  rdCol;
  } strobe_t;
endpackage

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
  import sbe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [COL_W-1:0]  colAddr,
  input  logic              apIn,
  input  logic              dqm,
  output strobe_t           strobes,
  output logic              apOut
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic isWrite, isRead;
  assign isWrite = (cmd == CMD_WRITE);
  assign isRead  = (cmd == CMD_READ);

  logic              wrActive, rdActive;
  logic [BEAT_W-1:0] wrBeat, rdBeat;
  logic [BANK_W-1:0] wrBank, rdBank;
  logic [COL_W-1:0]  wrBase, rdBase;

  // low column bits count within an aligned burst block, upper bits fixed
  function automatic logic [COL_W-1:0] beatCol(input logic [COL_W-1:0] base,
                                               input logic [BEAT_W-1:0] beat);
    logic [COL_W-1:0] r;
    r = base;
    r[BEAT_W-1:0] = base[BEAT_W-1:0] + beat;
    return r;
  endfunction

  // write burst tracker: any new READ/WRITE ends it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrActive <= 1'b0;
      wrBeat   <= '0;
      wrBank   <= '0;
      wrBase   <= '0;
    end else if (isWrite) begin
      wrActive <= 1'b1;
      wrBeat   <= BEAT_W'(1);
      wrBank   <= bankSel;
      wrBase   <= colAddr;
    end else if (isRead) begin
      wrActive <= 1'b0;
    end else if (wrActive) begin
      if (wrBeat == LAST_BEAT) wrActive <= 1'b0;
      wrBeat <= wrBeat + 1'b1;
    end
  end

  // read burst tracker: any new READ/WRITE ends it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdBeat   <= '0;
      rdBank   <= '0;
      rdBase   <= '0;
    end else if (isRead) begin
      rdActive <= 1'b1;
      rdBeat   <= BEAT_W'(1);
      rdBank   <= bankSel;
      rdBase   <= colAddr;
    end else if (isWrite) begin
      rdActive <= 1'b0;
    end else if (rdActive) begin
      if (rdBeat == LAST_BEAT) rdActive <= 1'b0;
      rdBeat <= rdBeat + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 apOut <= 1'b0;
    else if (isWrite || isRead) apOut <= apIn;
  end

  always_comb begin
    strobes = '0;
    if (isWrite) begin
      strobes.wrEn   = !dqm;
      strobes.wrBank = bankSel;
      strobes.wrCol  = colAddr;
    end else if (!isRead && wrActive) begin
      strobes.wrEn   = !dqm;
      strobes.wrBank = wrBank;
      strobes.wrCol  = beatCol(wrBase, wrBeat);
    end
    if (isRead) begin
      strobes.rdEn   = 1'b1;
      strobes.rdBank = bankSel;
      strobes.rdCol  = colAddr;
    end else if (!isWrite && rdActive) begin
      strobes.rdEn   = 1'b1;
      strobes.rdBank = rdBank;
      strobes.rdCol  = beatCol(rdBase, rdBeat);
    end
  end
endmodule

// File: rtl/sbe_datapath.sv
module sbe_datapath
  import sbe_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobes,
  input  logic [DQ_W-1:0] dqIn,
  input  logic            dqm,
  output logic [DQ_W-1:0] dqOut,
  output logic            dqOe
);
  localparam int ADDR_W = BANK_W + COL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DQ_W-1:0] mem [DEPTH];
  logic [DQ_W-1:0] pipeData [CAS_LAT];
  logic [CAS_LAT-1:0]  pipeVld;
  logic [MASK_LAT-1:0] maskPipe;
  logic [DQ_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.wrEn) begin
      mem[{strobes.wrBank, strobes.wrCol}] <= dqIn;
    end
  end

  assign rdWord = strobes.rdEn ? mem[{strobes.rdBank, strobes.rdCol}] : '0;

  // CAS latency delay line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeVld <= '0;
      for (int s = 0; s < CAS_LAT; s++) pipeData[s] <= '0;
    end else begin
      pipeVld[0]  <= strobes.rdEn;
      pipeData[0] <= rdWord;
      for (int s = 1; s < CAS_LAT; s++) begin
        pipeVld[s]  <= pipeVld[s-1];
        pipeData[s] <= pipeData[s-1];
      end
    end
  end

  // output blanking delay line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskPipe <= '0;
    end else begin
      maskPipe[0] <= dqm;
      for (int s = 1; s < MASK_LAT; s++) maskPipe[s] <= maskPipe[s-1];
    end
  end

  assign dqOe  = pipeVld[CAS_LAT-1] && !maskPipe[MASK_LAT-1];
  assign dqOut = dqOe ? pipeData[CAS_LAT-1] : '0;
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sbe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [COL_W-1:0]  colAddr,
  input  logic              apIn,
  input  logic [DQ_W-1:0]   dqIn,
  input  logic              dqm,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic              apOut
);
  strobe_t strobes;

  sbe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bankSel(bankSel), .colAddr(colAddr),
    .apIn(apIn), .dqm(dqm), .strobes(strobes), .apOut(apOut)
  );

  sbe_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dqIn(dqIn), .dqm(dqm),
    .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker
  import sbe_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      cmd,
  input logic            apIn,
  input logic            dqm,
  input logic [DQ_W-1:0] dqOut,
  input logic            dqOe,
  input logic            apOut
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rstN)         age <= '0;
    else if (age != 7) age <= age + 1'b1;
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age < 3) |-> !dqOe);

  // R5
  read_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 3 && $past(cmd, 3) == CMD_READ && !$past(dqm, 2)) |-> dqOe);

  // R7
  mask_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2 && $past(dqm, 2)) |-> !dqOe);

  // R8
  ap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_READ || cmd == CMD_WRITE) |=> (apOut == $past(apIn)));

  // R8
  ap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 1 && cmd != CMD_READ && cmd != CMD_WRITE) |=> $stable(apOut));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dqOut == '0));
endmodule

bind sdram_burst_engine sbe_checker u_chk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .apIn(apIn), .dqm(dqm),
  .dqOut(dqOut), .dqOe(dqOe), .apOut(apOut)
);

// File: tb/sdram_burst_engine_bench.sv
module sdram_burst_engine_bench;
  import sbe_pkg::*;
  localparam int NB = 1 << BANK_W;
  localparam int NC = 1 << COL_W;
  localparam int HIST = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [1:0] cmd;
  logic [BANK_W-1:0] bankSel;
  logic [COL_W-1:0] colAddr;
  logic apIn;
  logic [DQ_W-1:0] dqIn;
  logic dqm;
  logic [DQ_W-1:0] dqOut;
  logic dqOe, apOut;

  sdram_burst_engine u_sdram_burst_engine (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bankSel(bankSel), .colAddr(colAddr),
    .apIn(apIn), .dqIn(dqIn), .dqm(dqm), .dqOut(dqOut), .dqOe(dqOe), .apOut(apOut)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string curReq = "R1";

  logic [DQ_W-1:0] refMem [NB][NC];
  bit expVld [HIST];
  bit expMask [HIST];
  logic [DQ_W-1:0] expDat [HIST];
  bit mWrAct, mRdAct, mAp;
  int mWrBeat, mWrBank, mWrBase, mRdBeat, mRdBank, mRdBase;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic int beatCol(int base, int beat);
    return (base / BURST_LEN) * BURST_LEN + ((base + beat) % BURST_LEN);
  endfunction

  function automatic logic [DQ_W-1:0] pat(int k);
    return DQ_W'((k * 37 + 11) % 256);
  endfunction

  task automatic issueRead(int b, int c);
    int idx = (cyc + CAS_LAT) % HIST;
    expVld[idx] = 1;
    expDat[idx] = refMem[b][c];
  endtask

  // drive one cycle, advance the model, then check the next cycle's outputs
  task automatic step(logic [1:0] c, int b, int col, logic d7, logic [DQ_W-1:0] d, logic m);
    bit isW, isR;
    int idx;
    bit eo;
    cmd = c; bankSel = BANK_W'(b); colAddr = COL_W'(col); apIn = d7; dqIn = d; dqm = m;
    isW = (c == CMD_WRITE);
    isR = (c == CMD_READ);
    if (isR) issueRead(b, col);
    else if (!isW && mRdAct) issueRead(mRdBank, beatCol(mRdBase, mRdBeat));
    if (m) expMask[(cyc + MASK_LAT) % HIST] = 1;
    if (isW) begin
      if (!m) refMem[b][col] = d;
    end else if (!isR && mWrAct) begin
      if (!m) refMem[mWrBank][beatCol(mWrBase, mWrBeat)] = d;
    end
    if (isW) begin
      mWrAct = 1; mWrBeat = 1; mWrBank = b; mWrBase = col;
    end else if (isR) mWrAct = 0;
    else if (mWrAct) begin
      if (mWrBeat == BURST_LEN - 1) mWrAct = 0;
      mWrBeat = (mWrBeat + 1) % BURST_LEN;
    end
    if (isR) begin
      mRdAct = 1; mRdBeat = 1; mRdBank = b; mRdBase = col;
    end else if (isW) mRdAct = 0;
    else if (mRdAct) begin
      if (mRdBeat == BURST_LEN - 1) mRdAct = 0;
      mRdBeat = (mRdBeat + 1) % BURST_LEN;
    end
    if (isW || isR) mAp = d7;
    @(negedge clk);
    cyc++;
    idx = cyc % HIST;
    eo = expVld[idx] && !expMask[idx];
    check(expMask[idx] ? "R7" : "R5", "dqOe", 32'(dqOe), 32'(eo));
    if (eo) check(curReq, "dqOut", 32'(dqOut), 32'(expDat[idx]));
    else    check("R9", "dqOut idle", 32'(dqOut), 32'h0);
    check("R8", "apOut", 32'(apOut), 32'(mAp));
    expVld[idx] = 0;
    expMask[idx] = 0;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) step(CMD_NOP, 0, 0, 1'(cyc % 3 == 0), pat(cyc + 200), 1'b0);
  endtask

  // read every location back through the output path
  task automatic dumpAll(string req);
    curReq = req;
    for (int b = 0; b < NB; b++)
      for (int base = 0; base < NC; base += BURST_LEN) begin
        step(CMD_READ, b, base, 1'(b & 1), pat(cyc), 1'b0);
        nop(BURST_LEN - 1);
      end
    nop(CAS_LAT + 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired cycle=%0d actual=running expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int c = 0; c < NC; c++) refMem[b][c] = '0;
    for (int i = 0; i < HIST; i++) begin expVld[i] = 0; expMask[i] = 0; expDat[i] = '0; end
    mWrAct = 0; mRdAct = 0; mAp = 0;
    mWrBeat = 0; mWrBank = 0; mWrBase = 0; mRdBeat = 0; mRdBank = 0; mRdBase = 0;
    rstN = 1'b0; cmd = CMD_NOP; bankSel = '0; colAddr = '0; apIn = 1'b1; dqIn = '1; dqm = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "dqOe in reset", 32'(dqOe), 32'h0);
    check("R1", "dqOut in reset", 32'(dqOut), 32'h0);
    check("R1", "apOut in reset", 32'(apOut), 32'h0);
    rstN = 1'b1;
    dumpAll("R1");

    // R2: full bursts, every bank, several start columns incl. wrap
    curReq = "R2";
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NC; s += 5) begin
        step(CMD_WRITE, b, s, 1'(s & 1), pat(cyc), 1'b0);
        for (int k = 1; k < BURST_LEN; k++) step(CMD_NOP, 0, 0, 1'b0, pat(cyc), 1'b0);
      end
    dumpAll("R2");

    // R3: back-to-back writes and a mid-burst write cut
    curReq = "R3";
    for (int k = 0; k < 8; k++) step(CMD_WRITE, k % NB, (k * 3) % NC, 1'(k & 1), pat(cyc + 50), 1'b0);
    step(CMD_WRITE, 0, 2, 1'b1, pat(cyc + 50), 1'b0);
    step(CMD_NOP, 0, 0, 1'b0, pat(cyc + 50), 1'b0);
    step(CMD_WRITE, 2, 9, 1'b0, pat(cyc + 50), 1'b0);
    nop(4);
    dumpAll("R3");

    // R4: write cut by READ at beats 1..3, same and other bank, garbage dq
    curReq = "R4";
    for (int at = 1; at < BURST_LEN; at++)
      for (int other = 0; other < 2; other++) begin
        step(CMD_WRITE, 1, 4 * at + other, 1'b1, pat(cyc + 90), 1'b0);
        for (int k = 1; k < at; k++) step(CMD_NOP, 0, 0, 1'b0, pat(cyc + 90), 1'b0);
        step(CMD_READ, other ? 3 : 1, 4 * at, 1'b0, 8'hA5, 1'b0);
        nop(BURST_LEN + CAS_LAT);
      end
    dumpAll("R4");

    // R6: every write-mask pattern over four beats
    curReq = "R6";
    for (int mk = 0; mk < 16; mk++) begin
      step(CMD_WRITE, mk % NB, mk, 1'b0, pat(cyc + 130), 1'(mk & 1));
      for (int k = 1; k < BURST_LEN; k++) step(CMD_NOP, 0, 0, 1'b1, pat(cyc + 130), 1'((mk >> k) & 1));
    end
    dumpAll("R6");

    // R7: every read-side mask pattern over six cycles
    curReq = "R7";
    for (int mk = 0; mk < 64; mk++) begin
      step(CMD_READ, mk % NB, mk % NC, 1'(mk & 1), pat(cyc), 1'(mk & 1));
      for (int k = 1; k < 6; k++) step(CMD_NOP, 0, 0, 1'b0, pat(cyc), 1'((mk >> k) & 1));
      nop(2);
    end

    // R10: read bursts cut by READ and by WRITE
    curReq = "R10";
    step(CMD_READ, 0, 0, 1'b1, pat(cyc), 1'b0);
    step(CMD_NOP, 0, 0, 1'b0, pat(cyc), 1'b0);
    step(CMD_READ, 3, 6, 1'b0, pat(cyc), 1'b0);
    step(CMD_NOP, 0, 0, 1'b0, pat(cyc), 1'b0);
    step(CMD_NOP, 0, 0, 1'b0, pat(cyc), 1'b0);
    step(CMD_WRITE, 2, 1, 1'b1, pat(cyc + 170), 1'b0);
    nop(3);
    step(CMD_READ, 2, 0, 1'b0, pat(cyc), 1'b0);
    step(CMD_WRITE, 2, 0, 1'b1, pat(cyc + 170), 1'b0);
    nop(6);
    dumpAll("R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule